// File: doc/BRIEF.md
# Programmable Binary-Decode Frequency Divider

The block divides a slow reference signal by an integer N and emits one output pulse for every N reference periods. With the default divisor of 5000 a 500 kHz reference becomes a 100 Hz pulse train, which suits a counting gate for a frequency display. The reference is a plain level input that is sampled by the fast system clock. Each high-to-low transition of the reference advances a 14-bit binary up-counter by one.

The terminal count is not found with a full equality comparator. The block ANDs only those counter bits that are 1 in the binary form of N-1. An up-count that starts from zero reaches N-1 before any other value with all of those bits set, so this reduced decode is exact. It is also shallower and cheaper than a comparator. The terminal-count restart and the external reset are ORed into a single synchronous clear, so the counter runs 0 to N-1 and the period is exactly N reference cycles.

The divisor comes from a configuration input. The block takes it up only at a wrap or during reset, so a change never shortens a period that is already running. There is no streaming data path, so every pin is a plain control or status signal.

Top module: `binary_rate_divider`

## Requirements
- R1: A divisor input of 0 selects the default divisor of 5000. The distance between consecutive rising edges of `pulse_out` is then 5000 reference falling edges.
- R2: For any divisor from 2 to 16383, the distance between consecutive rising edges of `pulse_out` is exactly that many reference falling edges.
- R3: Only high-to-low transitions of `ref_in` advance the count. While `ref_in` is held steady, no output pulse appears and the count is preserved.
- R4: `pulse_out` rises on the reference falling edge at which the counter wraps to zero. It falls on the next reference falling edge, so it is high for exactly one reference period.
- R5: While `rst` is high (active high), `pulse_out` is 0 and the counter is cleared. After `rst` is released, the first pulse follows N reference falling edges, give or take the input synchronizer latency of two edges.
- R6: A new value on `div_in` takes effect only at the next wrap or reset. The period in progress when the value changes keeps its old length, and every following period has the new length.
- R7: A divisor input of 1 is treated as 2. The active divisor is never below 2.
- R8: The counter is cleared by the AND of only the counter bits that are 1 in N-1, ORed with the reset. The count never exceeds N-1. This holds for divisors with few set bits, such as 2, 3, 1025 and 4096, and for 16383.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the reference |
| rst | input | 1 | Synchronous active-high reset (power-on or external), merged with the terminal-count clear |
| ref_in | input | 1 | Reference signal to divide; asynchronous level, advances the count on its falling edge |
| div_in | input | CNT_W (14) | Divisor N; 0 selects the default, 1 is treated as 2 |
| pulse_out | output | 1 | Divided output, high for one reference period once every N reference periods |

## Verification
The assertions assume that each level of `ref_in` lasts at least one system clock cycle, so that every reference edge reaches the synchronizer. They also assume that the active divisor and the counter start together from a reset, which makes the counter's bound N-1 hold from the first active cycle. The stimulus toggles `ref_in` on every falling clock edge, which is the fastest reference the assumption allows. Every divisor test begins with a reset, and `div_in` is changed mid-period without a reset only in the test that checks deferred take-up. That test exercises the case in which the bound must survive a change of divisor.

// File: rtl/rate_div_pkg.sv
package rate_div_pkg;
  // Smallest divisor the block will run with.
  localparam int MinDivisor = 2;

  // Turn a raw configuration value into a usable divisor.
  function automatic int unsigned resolve_div(input int unsigned raw,
                                              input int unsigned dflt);
    if (raw == 0) return dflt;
    if (raw < MinDivisor) return MinDivisor;
    return raw;
  endfunction
endpackage

// File: rtl/rate_div_edge.sv
module rate_div_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_in,
  output logic fall_tick
);
  localparam int Last = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= sig_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], sig_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[Last];
  end

  assign fall_tick = prev_q & ~sync_q[Last];

  // R3: a falling transition needs a high sample then a low one, so ticks never touch
  p_tick_spaced_r3: assert property (@(posedge clk) disable iff (rst)
    fall_tick |=> !fall_tick);
endmodule

// File: rtl/rate_div_latch.sv
module rate_div_latch
  import rate_div_pkg::*;
#(
  parameter int CNT_W   = 14,
  parameter int DEF_DIV = 5000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrap,
  input  logic [CNT_W-1:0] div_in,
  output logic [CNT_W-1:0] mask
);
  logic [CNT_W-1:0] eff_div;
  logic [CNT_W-1:0] mask_q;

  always_comb begin
    eff_div = CNT_W'(resolve_div(int'(div_in), DEF_DIV));
  end

  // Take up a new divisor only at a restart point.
  always_ff @(posedge clk) begin
    if (rst || wrap) mask_q <= eff_div - CNT_W'(1);
  end

  assign mask = mask_q;

  // R6: the active divisor is frozen between restart points
  p_mask_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(mask_q));
  // R7: the active divisor is never below 2
  p_mask_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
    mask_q != '0);
endmodule

// File: rtl/rate_div_counter.sv
module rate_div_counter #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] mask,
  output logic             wrap,
  output logic             pulse
);
  logic [CNT_W-1:0] cnt_q;
  logic             hit;
  logic             clr;
  logic             pulse_q;

  // Reduced terminal-count decode: only the bits set in N-1 take part.
  assign hit  = ((cnt_q & mask) == mask);
  assign wrap = tick & hit;
  assign clr  = rst | wrap;

  always_ff @(posedge clk) begin
    if (clr)       cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)       pulse_q <= 1'b0;
    else if (tick) pulse_q <= hit;
  end

  assign pulse = pulse_q;

  // R8: the count never passes N-1
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= mask);
  // R2: a wrap restarts the count from zero
  p_wrap_clears_r2: assert property (@(posedge clk) disable iff (rst)
    wrap |=> cnt_q == '0);
  // R3: without a reference edge the count holds
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q));
  // R4: the output rises only right after a wrap
  p_pulse_from_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_q) |-> $past(wrap));
endmodule

// File: rtl/binary_rate_divider.sv
module binary_rate_divider #(
  parameter int CNT_W       = 14,
  parameter int DEF_DIV     = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_in,
  input  logic [CNT_W-1:0] div_in,
  output logic             pulse_out
);
  logic             tick;
  logic             wrap;
  logic [CNT_W-1:0] mask;

  rate_div_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .sig_in(ref_in), .fall_tick(tick)
  );

  rate_div_latch #(.CNT_W(CNT_W), .DEF_DIV(DEF_DIV)) u_latch (
    .clk(clk), .rst(rst), .wrap(wrap), .div_in(div_in), .mask(mask)
  );

  rate_div_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .mask(mask),
    .wrap(wrap), .pulse(pulse_out)
  );

  // R5: the output is low in the cycle after a reset
  p_reset_quiet_r5: assert property (@(posedge clk)
    rst |=> !pulse_out);
  // R4: the output changes only on a reference edge
  p_out_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(pulse_out));
endmodule

// File: tb/binary_rate_divider_test.sv
module binary_rate_divider_test;
  localparam int W = 14;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ref_in = 1'b0;
  logic [W-1:0] div_in = '0;
  logic         pulse_out;

  int  checks = 0;
  int  errors = 0;
  int  fe_cnt = 0;
  int  rise_cnt = 0;
  int  rise_fe = 0;
  int  cycles = 0;
  bit  ref_run = 1'b1;
  bit  pl_prev = 1'b0;
  bit  width_skip = 1'b1;

  always #4 clk = ~clk;

  binary_rate_divider uut (
    .clk(clk), .rst(rst), .ref_in(ref_in), .div_in(div_in), .pulse_out(pulse_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_div(input int raw);
    if (raw == 0) return 5000;
    if (raw < 2) return 2;
    return raw;
  endfunction

  // Reference generator and output monitor share one process.
  always @(negedge clk) begin
    cycles++;
    if (pulse_out && !pl_prev) begin
      rise_cnt++;
      rise_fe = fe_cnt;
      width_skip = 1'b0;
    end
    if (!pulse_out && pl_prev && !width_skip && !rst)
      check(fe_cnt - rise_fe == 1, "R4 width", fe_cnt - rise_fe, 1);
    if (rst) width_skip = 1'b1;
    pl_prev = pulse_out;
    if (ref_run) begin
      if (ref_in) fe_cnt++;
      ref_in <= ~ref_in;
    end
  end

  task automatic wait_rise(output int fe_at);
    int start;
    start = rise_cnt;
    while (rise_cnt == start) @(posedge clk);
    fe_at = rise_fe;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic measure(input int raw, input string tag);
    int a, b, n, rel;
    n = expect_div(raw);
    div_in = W'(raw);
    do_reset();
    rel = fe_cnt;
    wait_rise(a);
    check((a - rel >= n - 2) && (a - rel <= n + 2), "R5 first pulse", a - rel, n);
    wait_rise(b);
    check(b - a == n, tag, b - a, n);
  endtask

  initial begin
    int a, b, c, r;
    void'($urandom(32'd4711));

    // R5: reset state
    repeat (3) @(negedge clk);
    check(pulse_out == 1'b0, "R5 reset low", int'(pulse_out), 0);

    measure(0, "R1 default 5000");
    measure(1, "R7 one as two");
    measure(2, "R8 divide by 2");
    measure(3, "R8 divide by 3");
    measure(1025, "R8 divide by 1025");
    measure(4096, "R8 divide by 4096");
    measure(16383, "R2 divide by 16383");
    for (int i = 0; i < 6; i++) begin
      r = 2 + int'($urandom_range(598));
      measure(r, "R2 random divisor");
    end

    // R3: stall the reference; no pulse and the count is preserved
    div_in = W'(50);
    do_reset();
    wait_rise(a);
    repeat (30) @(negedge clk);
    ref_run = 1'b0;
    c = rise_cnt;
    repeat (2000) @(negedge clk);
    check(rise_cnt == c, "R3 steady ref", rise_cnt - c, 0);
    ref_run = 1'b1;
    wait_rise(b);
    check(b - a == 50, "R3 count kept", b - a, 50);

    // R6: divisor change mid-period is deferred to the wrap
    div_in = W'(300);
    do_reset();
    wait_rise(a);
    repeat (100) @(negedge clk);
    div_in = W'(100);
    wait_rise(b);
    check(b - a == 300, "R6 old period kept", b - a, 300);
    wait_rise(c);
    check(c - b == 100, "R6 new period", c - b, 100);

    // R5: reset in mid-count clears the output
    repeat (37) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(pulse_out == 1'b0, "R5 mid reset", int'(pulse_out), 0);
    rst = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles >= 190000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule